// File: doc/BRIEF.md
# Bus Test Target with Byte Sum Accumulator

This block is a small slave for an 8-bit peripheral bus. Its only job is to exercise a host's generic I/O bus controller. It answers with values that software can predict, in single-access mode and in burst mode. Every byte the host writes is added into an internal 8-bit running total. A read of address zero returns that total. A read of any other address returns the address's own three lowest bits. A burst read of the first eight-byte group therefore gives the total followed by the ladder 1 to 7, and the host can check the result without a separate reference.

In burst mode the host holds the burst input high and issues up to eight read or write strobes. The block generates the beat address itself. It starts from the address presented on the first beat, steps by one per beat and wraps inside the aligned eight-byte group. Dropping the burst input ends the burst. Read data is registered and appears one clock after the strobe. At every other time the data output is zero.

Top module: `bustgt_top`

## Requirements
- R1: While `rst_n` is low, the sum register is 0x00 and `rdata_o` is 0x00. The first read of address 0x00 after reset returns 0x00.
- R2: Each accepted write adds `wdata_i` to the sum modulo 256, whatever the address. For example 0x55 followed by 0xF0 gives 0x45.
- R3: A read of address 0x00 with `sel_i` high puts the sum on `rdata_o` on the next clock.
- R4: A read of a nonzero address returns the address bits [2:0] zero-extended to 8 bits on the next clock. For example 0xFF gives 0x07, 0x4A gives 0x02 and 0x09 gives 0x01.
- R5: In any cycle that follows a clock edge without an accepted read, `rdata_o` is 0x00.
- R6: Strobes with `sel_i` low change neither the sum nor the burst beat position. A burst resumes where it stopped once `sel_i` returns.
- R7: With `burst_i` high, the first strobed beat uses `addr_i`. Each later beat uses the next address, and bits [2:0] wrap modulo 8 while bits [7:3] stay those of the first beat. Cycles with no strobe do not advance the beat.
- R8: A burst accepts at most eight strobed beats. A ninth write leaves the sum unchanged, and a ninth read returns 0x00.
- R9: Taking `burst_i` low ends the burst. The next burst starts again from the address presented on its first beat.
- R10: When a read and a write are strobed in the same cycle at address 0x00, the read returns the sum from before that write, and the write is still added.
- R11: A burst write of 0x01, 0x02, 0x04 up to 0x80 starting at a zero sum leaves the sum at 0xFF. A following burst read from 0x00 returns 0xFF, 0x01, 0x02 up to 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| sel_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, one beat per cycle high |
| wr_i | input | 1 | Write strobe, one beat per cycle high |
| burst_i | input | 1 | Burst mode; held high for the whole burst |
| addr_i | input | 8 | Byte address; used on single accesses and the first burst beat |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Registered read data, zero when no read was accepted |

## Verification
The assertions assume that `burst_i` stays high for the whole of a burst. They also assume that single-access checks happen only with `burst_i` low, and that reset deassertion is already synchronous to `clk`. The stimulus changes every input on the falling edge only. It holds `burst_i` steady across each burst, including the cycles in which chip select is dropped. It also ends each burst with an explicit cycle that has `burst_i` low, so the next access starts from a cleared beat position.

// File: rtl/bustgt_pkg.sv
package bustgt_pkg;

  // Bus control bits sampled each cycle
  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
    logic bst;
  } bus_ctl_t;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_BURST  = 1'b1
  } xfer_mode_e;

endpackage

// File: rtl/bustgt_beat.sv
module bustgt_beat
  import bustgt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ctl_t          ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              wr_go_o,
  output logic              rd_go_o
);

  localparam int LANE_W = $clog2(BURST_LEN);
  localparam int CNT_W  = LANE_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              cnt_en, base_en;
  logic              strobe, room, first, beat_ok;
  logic [LANE_W-1:0] lane;
  logic [ADDR_W-LANE_W-1:0] group;
  xfer_mode_e        mode;

  always_comb begin
    mode   = ctl_i.bst ? XFER_BURST : XFER_SINGLE;
    strobe = ctl_i.sel & (ctl_i.rd | ctl_i.wr);
    room   = (cnt_q < CNT_MAX);
    first  = (cnt_q == '0);

    // Lane offset wraps inside the aligned group
    if (first) begin
      lane  = addr_i[LANE_W-1:0];
      group = addr_i[ADDR_W-1:LANE_W];
    end else begin
      lane  = base_q[LANE_W-1:0] + cnt_q[LANE_W-1:0];
      group = base_q[ADDR_W-1:LANE_W];
    end

    if (mode == XFER_BURST) begin
      beat_addr_o = {group, lane};
      beat_ok     = room;
    end else begin
      beat_addr_o = addr_i;
      beat_ok     = 1'b1;
    end

    wr_go_o = ctl_i.sel & ctl_i.wr & beat_ok;
    rd_go_o = ctl_i.sel & ctl_i.rd & beat_ok;

    // Beat counter: cleared outside a burst, frozen when unselected
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (mode == XFER_SINGLE) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (strobe && room) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end

    base_en = (mode == XFER_BURST) & strobe & first;
    base_d  = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  // R8: the beat position never passes the burst length
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R9: leaving burst mode clears the beat position
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i.bst |=> cnt_q == '0);

  // R6: an unselected cycle inside a burst keeps the beat position
  assert_cnt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.sel && ctl_i.bst) |=> $stable(cnt_q));

endmodule

// File: rtl/bustgt_acc.sv
module bustgt_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en_i,
  input  logic [DATA_W-1:0] add_val_i,
  output logic [DATA_W-1:0] sum_o
);

  logic [DATA_W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q + add_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (add_en_i) begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

  // R6: without an accepted write the total is unchanged
  assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en_i |=> $stable(sum_q));

endmodule

// File: rtl/bustgt_rdret.sv
module bustgt_rdret #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [DATA_W-1:0] sum_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rdata_q, rdata_d, pattern;

  always_comb begin
    pattern = DATA_W'(beat_addr_i[LANE_W-1:0]);
    if (!rd_go_i) begin
      rdata_d = '0;
    end else if (beat_addr_i == '0) begin
      rdata_d = sum_i;
    end else begin
      rdata_d = pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R5: the output returns to zero after a cycle without an accepted read
  assert_rdata_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go_i |=> rdata_q == '0);

endmodule

// File: rtl/bustgt_top.sv
module bustgt_top
  import bustgt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LANE_W = $clog2(BURST_LEN);

  bus_ctl_t          ctl;
  logic [ADDR_W-1:0] beat_addr;
  logic              wr_go, rd_go;
  logic [DATA_W-1:0] sum;

  assign ctl = '{sel: sel_i, rd: rd_i, wr: wr_i, bst: burst_i};

  bustgt_beat #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_i       (ctl),
    .addr_i      (addr_i),
    .beat_addr_o (beat_addr),
    .wr_go_o     (wr_go),
    .rd_go_o     (rd_go)
  );

  bustgt_acc #(
    .DATA_W (DATA_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_en_i  (wr_go),
    .add_val_i (wdata_i),
    .sum_o     (sum)
  );

  bustgt_rdret #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_rdret (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_go_i     (rd_go),
    .beat_addr_i (beat_addr),
    .sum_i       (sum),
    .rdata_o     (rdata_o)
  );

  // R2: a selected single write adds its byte modulo the data width
  assert_single_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && !burst_i) |=> sum == DATA_W'($past(sum) + $past(wdata_i)));

  // R3: a single read of address zero returns the pre-edge total
  assert_addr0_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rd_i && !burst_i && addr_i == '0) |=> rdata_o == $past(sum));

  // R4: a single read elsewhere returns the low address bits
  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rd_i && !burst_i && addr_i != '0)
      |=> rdata_o == DATA_W'($past(addr_i[LANE_W-1:0])));

  // R5: with no selected read the port reads zero next cycle
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && rd_i) |=> rdata_o == '0);

endmodule

// File: tb/test_bustgt_top.sv
`timescale 1ns/1ps
module test_bustgt_top;

  logic       clk;
  logic       rst_n;
  logic       sel, rd, wr, bst;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bustgt_top i_bustgt_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel),
    .rd_i    (rd),
    .wr_i    (wr),
    .burst_i (bst),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {req[3:0], {sel,rd,wr,bst}, addr, wdata, chk, expected}
  localparam int N = 52;
  localparam logic [32:0] VEC [0:N-1] = '{
    {4'd2,  4'b1010, 8'h01, 8'h55, 1'b0, 8'h00}, // R2 single write 0x55
    {4'd3,  4'b1100, 8'h00, 8'h00, 1'b1, 8'h55}, // R3 read sum
    {4'd4,  4'b1100, 8'hFF, 8'h00, 1'b1, 8'h07}, // R4
    {4'd4,  4'b1100, 8'h4A, 8'h00, 1'b1, 8'h02}, // R4
    {4'd4,  4'b1100, 8'h09, 8'h00, 1'b1, 8'h01}, // R4
    {4'd5,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}, // R5 idle
    {4'd2,  4'b1010, 8'h80, 8'hF0, 1'b0, 8'h00}, // R2 wraps to 0x45
    {4'd2,  4'b1100, 8'h00, 8'h00, 1'b1, 8'h45}, // R2
    {4'd6,  4'b0010, 8'h00, 8'h11, 1'b0, 8'h00}, // R6 unselected write
    {4'd5,  4'b0100, 8'h00, 8'h00, 1'b1, 8'h00}, // R5 unselected read
    {4'd6,  4'b1100, 8'h00, 8'h00, 1'b1, 8'h45}, // R6 sum unchanged
    {4'd10, 4'b1110, 8'h00, 8'h10, 1'b1, 8'h45}, // R10 read+write
    {4'd10, 4'b1100, 8'h00, 8'h00, 1'b1, 8'h55}, // R10 write applied
    {4'd2,  4'b1010, 8'h00, 8'hAB, 1'b0, 8'h00}, // R2 sum -> 0x00
    {4'd2,  4'b1100, 8'h00, 8'h00, 1'b1, 8'h00}, // R2
    {4'd11, 4'b1011, 8'h00, 8'h01, 1'b0, 8'h00}, // R11 ladder write
    {4'd11, 4'b1011, 8'h00, 8'h02, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h04, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h08, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h10, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h20, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h40, 1'b0, 8'h00},
    {4'd11, 4'b1011, 8'h00, 8'h80, 1'b0, 8'h00},
    {4'd8,  4'b1011, 8'h00, 8'h33, 1'b0, 8'h00}, // R8 ninth write dropped
    {4'd9,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}, // R9 end burst
    {4'd8,  4'b1100, 8'h00, 8'h00, 1'b1, 8'hFF}, // R8 / R11 sum is 0xFF
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'hFF}, // R11 ladder read
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h01},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h02},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h03},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h04},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h05},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h06},
    {4'd11, 4'b1101, 8'h00, 8'h00, 1'b1, 8'h07},
    {4'd8,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h00}, // R8 ninth read
    {4'd9,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}, // R9
    {4'd7,  4'b1101, 8'h05, 8'h00, 1'b1, 8'h05}, // R7 start mid-group
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h06},
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h07},
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'hFF}, // R7 wrap to 0x00
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h01},
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h02},
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h03},
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h04},
    {4'd9,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}, // R9
    {4'd7,  4'b1101, 8'h0E, 8'h00, 1'b1, 8'h06}, // R7 group 0x08
    {4'd6,  4'b0101, 8'h00, 8'h00, 1'b1, 8'h00}, // R6 deselected beat
    {4'd6,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h07}, // R6 resumes at 0x0F
    {4'd7,  4'b1101, 8'h00, 8'h00, 1'b1, 8'h00}, // R7 wraps to 0x08
    {4'd9,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}, // R9
    {4'd9,  4'b1101, 8'h03, 8'h00, 1'b1, 8'h03}, // R9 restart at 0x03
    {4'd9,  4'b0000, 8'h00, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [7:0] a, input logic [7:0] d);
    {sel, rd, wr, bst} = c;
    addr  = a;
    wdata = d;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(4'b0000, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check(1, rdata, 8'h00);                 // R1 during reset
    rst_n = 1'b1;
    drive(4'b1100, 8'h00, 8'h00);           // R1 first read of sum
    @(negedge clk);
    check(1, rdata, 8'h00);

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][28:25], VEC[i][24:17], VEC[i][16:9]);
      @(negedge clk);
      if (VEC[i][8]) check(int'(VEC[i][32:29]), rdata, VEC[i][7:0]);
    end

    // R7: cycles without a strobe do not advance the beat
    for (int k = 0; k < 3; k++) begin
      drive(4'b1001, 8'h00, 8'h00);
      @(negedge clk);
    end
    drive(4'b1101, 8'h02, 8'h00);
    @(negedge clk);
    check(7, rdata, 8'h02);
    drive(4'b1101, 8'h00, 8'h00);
    @(negedge clk);
    check(7, rdata, 8'h03);
    drive(4'b0000, 8'h00, 8'h00);
    @(negedge clk);

    // R1: reset during operation clears output and sum
    drive(4'b1100, 8'h07, 8'h00);
    @(negedge clk);
    check(4, rdata, 8'h07);
    drive(4'b0000, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    check(1, rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b1100, 8'h00, 8'h00);
    @(negedge clk);
    check(1, rdata, 8'h00);
    drive(4'b0000, 8'h00, 8'h00);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule